// File: doc/BRIEF.md
# Backlight PWM Generator with MSB-Aligned Brightness

This block makes the single pulse-width-modulated signal that dims a display backlight. It runs from a 27 MHz reference clock. The pulse period is set by two values: an 8-bit prescaler and a power-of-two exponent. The exponent is first limited to a window given by a lower and an upper capability bound. It then also sets how many brightness bits actually control the duty cycle.

Brightness arrives as a 16-bit word. A mode bit chooses between using the whole word (wide mode) and using only its low byte (narrow mode). In both modes the value is treated as left-aligned, and only its top bits are used, as many as the exponent allows. The bits below them are dropped. Because of this, software can always write a full-scale value and let the block keep the resolution it is set to.

Setting changes are held back until the current period ends, so the output never shows a partial pulse. Dropping the enable turns the output off and rewinds the period.

Top module: `bl_pwm_gen`

## Requirements
- R1: With the enable held high, one period lasts F × 2^P reference clocks. F is the prescaler, and a prescaler of 0 is treated as 1. P is the applied exponent.
- R2: The applied exponent P is computed from the requested exponent in this order:
  - it is raised to `cap_lo` if it is below;
  - it is then lowered to `cap_hi` if it is above, so `cap_hi` wins when the bounds conflict;
  - it is then held to at most 16;
  - a result of 0 becomes 1.
- R3: In wide mode (`wide`=1), the active value A is `level >> (16−P)`. The output is high for the first F × A clocks of each period.
- R4: In narrow mode (`wide`=0), the word used is `{level[7:0], 8'h00}`. `level[15:8]` has no effect on the output. When P exceeds 8, the byte is padded with zeros below.
- R5: Bits of the brightness word below the top P bits (top 8 in narrow mode when P exceeds 8) have no effect on the output.
- R6: A zero active value keeps the output low for the whole period. When the top min(P, word width) bits of the used word are all ones, the output stays high for the whole period.
- R7: The output is low after reset and whenever `enable` is low. Each edge with `enable` low clears the counters. After `enable` rises, the next clock starts a fresh period at its first step.
- R8: Changes to the prescaler, the exponent inputs, the mode bit and `level` that are made while running take effect only at the next period boundary.
- R9: Within a period, the output is one high run that starts at the first clock of the period, followed by low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 27 MHz reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| enable | input | 1 | Runs the generator; low forces the output low and rewinds the period |
| prescale | input | 8 | Prescaler F (0 acts as 1) |
| bitcount | input | 5 | Requested exponent P before limiting |
| cap_lo | input | 5 | Lower bound for the exponent |
| cap_hi | input | 5 | Upper bound for the exponent |
| wide | input | 1 | 1 = 16-bit brightness word, 0 = low byte only |
| level | input | 16 | Brightness word, left-aligned |
| pwm_out | output | 1 | Backlight PWM output |

## Verification
The bench measures whole periods and checks several cases:
- **Full-scale value:** a design that compares the full-scale value against the counter would emit one low step per period instead of staying high.
- **Narrow mode with P above 8:** a design that forgets the zero padding would shrink the pulse by a power of two.
- **Conflicting capability bounds:** if the lower bound won, the period length would be wrong.
- **Settings changed in mid-period:** a design that picks them up early would show a torn period whose high count matches neither setting.
- **Enable dropped during a high phase:** a slow turn-off would show up here.
- **Prescaler of zero:** a divider that treats zero literally would hang the period.

// File: rtl/bl_pkg.sv
package bl_pkg;
  localparam int BL_PRE_W = 8;
  localparam int BL_EXP_W = 5;
  localparam int BL_LVL_W = 16;
  localparam int BL_NAR_W = 8;
endpackage

// File: rtl/bl_cfg_stage.sv
module bl_cfg_stage
  import bl_pkg::*;
#(
  parameter int PRE_W = BL_PRE_W,
  parameter int EXP_W = BL_EXP_W,
  parameter int LVL_W = BL_LVL_W,
  parameter int NAR_W = BL_NAR_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [PRE_W-1:0] prescale,
  input  logic [EXP_W-1:0] bitcount,
  input  logic [EXP_W-1:0] cap_lo,
  input  logic [EXP_W-1:0] cap_hi,
  input  logic             wide,
  input  logic [LVL_W-1:0] level,
  output logic [PRE_W-1:0] f_q,
  output logic [EXP_W-1:0] pn_q,
  output logic [LVL_W-1:0] act_q,
  output logic             full_q
);
  localparam logic [EXP_W-1:0] EXP_LIM = EXP_W'(LVL_W);
  localparam logic [EXP_W-1:0] NAR_LIM = EXP_W'(NAR_W);
  localparam int               PAD_W   = LVL_W - NAR_W;

  logic [PRE_W-1:0] f_d;
  logic [EXP_W-1:0] pn_d;
  logic [EXP_W-1:0] keep_d;
  logic [LVL_W-1:0] word_d;
  logic [LVL_W-1:0] act_d;
  logic [LVL_W-1:0] mask_d;
  logic             full_d;

  // Next-state: limit the exponent and extract the active bits
  always_comb begin
    f_d = (prescale == '0) ? PRE_W'(1) : prescale;
    pn_d = bitcount;
    if (pn_d < cap_lo) pn_d = cap_lo;
    if (pn_d > cap_hi) pn_d = cap_hi;
    if (pn_d > EXP_LIM) pn_d = EXP_LIM;
    if (pn_d == '0) pn_d = EXP_W'(1);
    keep_d = wide ? pn_d : ((pn_d > NAR_LIM) ? NAR_LIM : pn_d);
    word_d = wide ? level : {level[NAR_W-1:0], {PAD_W{1'b0}}};
    act_d  = word_d >> (EXP_LIM - pn_d);
    mask_d = {LVL_W{1'b1}} << (EXP_LIM - keep_d);
    full_d = ((word_d & mask_d) == mask_d);
  end

  // Shadow registers, loaded only when the timebase allows it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f_q    <= PRE_W'(1);
      pn_q   <= EXP_W'(1);
      act_q  <= '0;
      full_q <= 1'b0;
    end else if (load_en) begin
      f_q    <= f_d;
      pn_q   <= pn_d;
      act_q  <= act_d;
      full_q <= full_d;
    end
  end

  // R2
  pn_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pn_q != '0) && (pn_q <= EXP_LIM));

  // R1
  f_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    f_q != '0);
endmodule

// File: rtl/bl_timebase.sv
module bl_timebase
  import bl_pkg::*;
#(
  parameter int PRE_W = BL_PRE_W,
  parameter int EXP_W = BL_EXP_W,
  parameter int LVL_W = BL_LVL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [PRE_W-1:0] f_cur,
  input  logic [EXP_W-1:0] pn_cur,
  output logic             run_q,
  output logic [LVL_W-1:0] step_q,
  output logic             boundary
);
  localparam logic [EXP_W-1:0] EXP_LIM = EXP_W'(LVL_W);

  logic [PRE_W-1:0] pre_q, pre_d;
  logic [LVL_W-1:0] step_d;
  logic [LVL_W-1:0] top;
  logic             run_d;
  logic             tick;
  logic             wrap;

  assign top      = {LVL_W{1'b1}} >> (EXP_LIM - pn_cur);
  assign tick     = (pre_q == (f_cur - PRE_W'(1)));
  assign wrap     = (step_q == top);
  assign boundary = run_q & tick & wrap;

  // Next-state
  always_comb begin
    pre_d  = pre_q;
    step_d = step_q;
    run_d  = enable;
    if (!enable) begin
      pre_d  = '0;
      step_d = '0;
    end else if (run_q) begin
      if (tick) begin
        pre_d  = '0;
        step_d = wrap ? '0 : step_q + LVL_W'(1);
      end else begin
        pre_d = pre_q + PRE_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      step_q <= '0;
      run_q  <= 1'b0;
    end else begin
      pre_q  <= pre_d;
      step_q <= step_d;
      run_q  <= run_d;
    end
  end

  // R1
  pre_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (pre_q < f_cur));

  // R1
  step_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_q <= top);

  // R7
  idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (step_q == '0) && (pre_q == '0) && !run_q);
endmodule

// File: rtl/bl_duty.sv
module bl_duty
  import bl_pkg::*;
#(
  parameter int LVL_W = BL_LVL_W
) (
  input  logic             enable,
  input  logic             run_q,
  input  logic [LVL_W-1:0] step_q,
  input  logic [LVL_W-1:0] act,
  input  logic             full,
  output logic             pwm_out
);
  assign pwm_out = enable & run_q & (full | (step_q < act));
endmodule

// File: rtl/bl_pwm_gen.sv
module bl_pwm_gen
  import bl_pkg::*;
#(
  parameter int PRE_W = BL_PRE_W,
  parameter int EXP_W = BL_EXP_W,
  parameter int LVL_W = BL_LVL_W,
  parameter int NAR_W = BL_NAR_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [PRE_W-1:0] prescale,
  input  logic [EXP_W-1:0] bitcount,
  input  logic [EXP_W-1:0] cap_lo,
  input  logic [EXP_W-1:0] cap_hi,
  input  logic             wide,
  input  logic [LVL_W-1:0] level,
  output logic             pwm_out
);
  logic [1:0]       rsync_q;
  logic             rst_core_n;
  logic [PRE_W-1:0] f_s;
  logic [EXP_W-1:0] pn_s;
  logic [LVL_W-1:0] act_s;
  logic             full_s;
  logic             run_q;
  logic [LVL_W-1:0] step_q;
  logic             boundary;
  logic             load_en;

  // Reset: asserted at once, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_core_n = rsync_q[1];

  assign load_en = !run_q | boundary;

  bl_cfg_stage #(.PRE_W(PRE_W), .EXP_W(EXP_W), .LVL_W(LVL_W), .NAR_W(NAR_W)) u_cfg (
    .clk(clk), .rst_n(rst_core_n), .load_en(load_en),
    .prescale(prescale), .bitcount(bitcount), .cap_lo(cap_lo), .cap_hi(cap_hi),
    .wide(wide), .level(level),
    .f_q(f_s), .pn_q(pn_s), .act_q(act_s), .full_q(full_s)
  );

  bl_timebase #(.PRE_W(PRE_W), .EXP_W(EXP_W), .LVL_W(LVL_W)) u_tb (
    .clk(clk), .rst_n(rst_core_n), .enable(enable),
    .f_cur(f_s), .pn_cur(pn_s),
    .run_q(run_q), .step_q(step_q), .boundary(boundary)
  );

  bl_duty #(.LVL_W(LVL_W)) u_duty (
    .enable(enable), .run_q(run_q), .step_q(step_q),
    .act(act_s), .full(full_s), .pwm_out(pwm_out)
  );

  // R8
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (run_q && !boundary) |=> ($stable(act_s) && $stable(f_s) && $stable(pn_s) && $stable(full_s)));

  // R9
  start_high_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (enable && run_q && step_q == '0 && (act_s != '0 || full_s)) |-> pwm_out);

  // R6
  zero_low_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (act_s == '0 && !full_s) |-> !pwm_out);

  // R7
  off_low_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    !enable |-> !pwm_out);
endmodule

// File: tb/tb_bl_pwm_gen.sv
module tb_bl_pwm_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic [7:0]  prescale = 8'd1;
  logic [4:0]  bitcount = 5'd1;
  logic [4:0]  cap_lo = 5'd0;
  logic [4:0]  cap_hi = 5'd31;
  logic        wide = 1'b1;
  logic [15:0] level = 16'h0;
  logic        pwm_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  bl_pwm_gen dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .prescale(prescale),
    .bitcount(bitcount), .cap_lo(cap_lo), .cap_hi(cap_hi),
    .wide(wide), .level(level), .pwm_out(pwm_out)
  );

  function automatic int exp_pn(int bc, int lo, int hi);
    int p = bc;
    if (p < lo) p = lo;
    if (p > hi) p = hi;
    if (p > 16) p = 16;
    if (p == 0) p = 1;
    return p;
  endfunction

  function automatic int exp_high(int f, int p, bit w, int lvl);
    int fe = (f == 0) ? 1 : f;
    int word = w ? (lvl & 'hFFFF) : ((lvl & 'hFF) << 8);
    int k = w ? p : ((p > 8) ? 8 : p);
    int mask = ('hFFFF << (16 - k)) & 'hFFFF;
    if ((word & mask) == mask) return fe << p;
    return fe * (word >> (16 - p));
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic apply(int f, int bc, int lo, int hi, bit w, int lvl);
    prescale = 8'(f); bitcount = 5'(bc); cap_lo = 5'(lo); cap_hi = 5'(hi);
    wide = w; level = 16'(lvl);
  endtask

  task automatic start(int f, int bc, int lo, int hi, bit w, int lvl);
    @(negedge clk) enable = 1'b0;
    @(negedge clk);
    apply(f, bc, lo, hi, w, lvl);
    enable = 1'b1;
  endtask

  task automatic measure(int len, output int highs, output bit shape_ok);
    bit seen_low = 0;
    highs = 0;
    shape_ok = 1;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (pwm_out) begin
        highs++;
        if (seen_low) shape_ok = 0;
      end else seen_low = 1;
    end
  endtask

  task automatic run_case(int f, int bc, int lo, int hi, bit w, int lvl, int nper, string req);
    int p = exp_pn(bc, lo, hi);
    int fe = (f == 0) ? 1 : f;
    int len = fe << p;
    int eh = exp_high(f, p, w, lvl);
    int h;
    bit sh;
    start(f, bc, lo, hi, w, lvl);
    for (int n = 0; n < nper; n++) begin
      measure(len, h, sh);
      chk(h == eh, req, h, eh);
      chk(sh, "R9 shape", int'(sh), 1);
    end
  endtask

  initial begin
    int h;
    bit sh;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(pwm_out == 1'b0, "R7 reset low", int'(pwm_out), 0);

    // R3 wide mode, 0x0FFF at several exponents
    run_case(1, 6, 0, 31, 1, 'h0FFF, 2, "R3 p6");
    run_case(1, 12, 0, 31, 1, 'h0FFF, 2, "R3 p12");
    run_case(1, 16, 0, 31, 1, 'h0FFF, 1, "R3 p16");
    // R1 prescaler, including zero
    run_case(0, 3, 0, 31, 1, 'h6000, 2, "R1 f0");
    run_case(3, 5, 0, 31, 1, 'h8000, 2, "R1 f3");
    // R2 exponent limiting
    run_case(1, 20, 3, 5, 1, 'h4000, 2, "R2 upper");
    run_case(1, 1, 4, 9, 1, 'h4000, 2, "R2 lower");
    run_case(1, 0, 0, 0, 1, 'h4000, 2, "R2 zero");
    run_case(1, 9, 10, 6, 1, 'h4000, 2, "R2 conflict");
    // R4 narrow mode
    run_case(1, 4, 0, 31, 0, 'hAB80, 2, "R4 narrow");
    run_case(1, 4, 0, 31, 0, 'h1280, 2, "R4 upper byte");
    run_case(1, 10, 0, 31, 0, 'h0040, 2, "R4 pad");
    // R6 extremes
    run_case(1, 10, 0, 31, 0, 'h00FF, 2, "R6 narrow full");
    run_case(2, 4, 0, 31, 1, 'hF000, 2, "R6 wide full");
    run_case(2, 3, 0, 31, 1, 'h0FFF, 2, "R6 zero");
    // R5 low bits dropped
    run_case(1, 4, 0, 31, 1, 'h5FFF, 2, "R5 ones");
    run_case(1, 4, 0, 31, 1, 'h5000, 2, "R5 zeros");

    // R8 mid-period change
    start(2, 4, 0, 31, 1, 'h8000);
    begin
      int cnt = 0;
      for (int i = 0; i < 32; i++) begin
        @(negedge clk);
        if (pwm_out) cnt++;
        if (i == 4) begin
          level = 16'h2000;
          prescale = 8'd3;
        end
      end
      chk(cnt == 16, "R8 old period", cnt, 16);
    end
    measure(48, h, sh);
    chk(h == 6, "R8 new period", h, 6);

    // R7 enable dropped during high phase, then restart
    @(negedge clk);
    chk(pwm_out == 1'b1, "R7 high before drop", int'(pwm_out), 1);
    enable = 1'b0;
    #1;
    chk(pwm_out == 1'b0, "R7 off at once", int'(pwm_out), 0);
    @(negedge clk);
    chk(pwm_out == 1'b0, "R7 stays off", int'(pwm_out), 0);
    enable = 1'b1;
    measure(48, h, sh);
    chk(h == 6 && sh, "R7 restart", h, 6);

    // Random cases
    void'($urandom(32'd4242));
    for (int r = 0; r < 30; r++) begin
      int f = int'($urandom % 5);
      int lo = int'($urandom % 4);
      int hi = 3 + int'($urandom % 5);
      int bc = int'($urandom % 8);
      bit w = 1'($urandom % 2);
      int lvl = int'($urandom & 'hFFFF);
      run_case(f, bc, lo, hi, w, lvl, 2, w ? "R3 random" : "R4 random");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule